// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a compact processor that completes one 32-bit instruction on every clock edge. On each cycle it reads the instruction at the current program counter, decodes it, reads up to two source registers, computes a result or an address, and then commits a register write, a memory write and the next program counter, all on the same rising edge. The supported subset is register add, subtract, signed set-less-than and logical right shift, immediate add, word load, word store, branch on equal, branch on not-equal and an absolute jump.

Instruction and data storage are word-wide arrays inside the block. While the core is held in reset, a testbench or a boot loader fills the instruction array through a simple write port. Three combinational observation ports are provided: one register, one data word and the program counter. All addresses are byte addresses. The arrays are indexed by address bits [N+1:2] and wrap past their size.

Top module: `mini_core`

## Requirements
- R1: While reset is low, the program counter reads 0, every register reads 0 and every data word reads 0. The reset acts at once, without waiting for a clock edge.
- R2: Register 0 always reads as 0 as a source operand and on the observation port, and any write to it is dropped.
- R3: The encoding has three formats. R is op[31:26] rs[25:21] rt[20:16] rd[15:11] shamt[10:6] funct[5:0]. I is op, rs, rt and imm[15:0]. J is op and target[25:0]. With op 0, funct 32 writes rs+rt to rd and funct 34 writes rs-rt to rd. Op 8 writes rs plus the sign-extended immediate to rt. All three wrap modulo 2^32.
- R4: Op 0 with funct 42 writes 1 to rd when rs is less than rt as signed values, and writes 0 otherwise.
- R5: Op 0 with funct 2 writes rt shifted right by shamt, with zero fill, to rd.
- R6: Op 35 loads the data word at byte address rs+sext(imm) into rt. Op 43 stores rt to that address. The data word index is address bits [DW+1:2], and a store changes no register.
- R7: A non-control instruction advances the PC by 4. Op 4 (equal) and op 5 (not equal) compare rs with rt. When taken, the next PC is PC+4+sext(imm)*4; when not taken, it is PC+4.
- R8: Op 2 jumps to {(PC+4)[31:28], target, 2'b00}.
- R9: Any other opcode, and any other funct under op 0, changes no register and no data word, and it advances the PC by 4.
- R10: With loadEn high, the word at loadAddr in the instruction array takes loadData on the rising edge. The program counter is always a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Instruction array write strobe |
| loadAddr | input | IAW | Instruction word index to write |
| loadData | input | 32 | Instruction word to write |
| dbgRegSel | input | 5 | Register to observe |
| dbgRegData | output | 32 | Value of the selected register |
| dbgMemAddr | input | DAW | Data word index to observe |
| dbgMemData | output | 32 | Value of the selected data word |
| pcOut | output | 32 | Current program counter |

## Verification
The bench aims at the sign handling of the 16-bit immediate. A negative offset that was zero-extended would send the stores to the wrong word and would turn the backward loop branch into a far forward jump. It also compares operands whose order differs between signed and unsigned readings, so that an unsigned set-less-than gives the opposite answer. It checks the logical shift of a negative value, so that an arithmetic shift would leave ones in the top bits. It also runs a taken branch, a not-taken branch, a skipped instruction after each taken branch, a write to register 0, and unknown opcode and funct words, so that a misdecode would show up as a stray register value or a wrong PC. Finally it applies reset in the middle of a run to catch state that reset does not clear, and it reloads the program so that a jump back to an early address must land exactly.

// File: rtl/mini_core_pkg.sv
`timescale 1ns/1ps
package mini_core_pkg;

  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_SRL = 6'd2;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_SLT = 2'd2,
    ALU_SRL = 2'd3
  } aluOpT;

  // Strobes from decode to datapath
  typedef struct packed {
    logic  regWrite;
    logic  dstIsRd;
    logic  srcImm;
    logic  memWrite;
    logic  memToReg;
    logic  brEq;
    logic  brNe;
    logic  jump;
    aluOpT aluOp;
  } ctrlT;

endpackage

// File: rtl/mini_core_ctrl.sv
`timescale 1ns/1ps
module mini_core_ctrl
  import mini_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrlT       ctl
);

  always_comb begin
    ctl = '0;
    unique case (opcode)
      OP_RTYPE: begin
        unique case (funct)
          FN_ADD: begin ctl.regWrite = 1'b1; ctl.dstIsRd = 1'b1; ctl.aluOp = ALU_ADD; end
          FN_SUB: begin ctl.regWrite = 1'b1; ctl.dstIsRd = 1'b1; ctl.aluOp = ALU_SUB; end
          FN_SLT: begin ctl.regWrite = 1'b1; ctl.dstIsRd = 1'b1; ctl.aluOp = ALU_SLT; end
          FN_SRL: begin ctl.regWrite = 1'b1; ctl.dstIsRd = 1'b1; ctl.aluOp = ALU_SRL; end
          default: ;  // unknown funct: no-op (R9)
        endcase
      end
      OP_ADDI: begin
        ctl.regWrite = 1'b1;
        ctl.srcImm   = 1'b1;
      end
      OP_LW: begin
        ctl.regWrite = 1'b1;
        ctl.srcImm   = 1'b1;
        ctl.memToReg = 1'b1;
      end
      OP_SW: begin
        ctl.srcImm   = 1'b1;
        ctl.memWrite = 1'b1;
      end
      OP_BEQ:  ctl.brEq = 1'b1;
      OP_BNE:  ctl.brNe = 1'b1;
      OP_JUMP: ctl.jump = 1'b1;
      default: ;  // unknown opcode: no-op (R9)
    endcase
  end

endmodule

// File: rtl/mini_core_regs.sv
`timescale 1ns/1ps
module mini_core_regs #(
  parameter int NREG   = 32,
  parameter int WIDTH  = 32,
  parameter int NREAD  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [$clog2(NREG)-1:0] rdAddr [NREAD],
  output logic [WIDTH-1:0]        rdData [NREAD],
  input  logic                    wrEn,
  input  logic [$clog2(NREG)-1:0] wrAddr,
  input  logic [WIDTH-1:0]        wrData
);

  localparam int AW = $clog2(NREG);

  logic [WIDTH-1:0] bank [NREG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (wrEn && (wrAddr != AW'(0))) begin
      bank[wrAddr] <= wrData;
    end
  end

  // One combinational read port per requester; index 0 is hard zero
  for (genvar p = 0; p < NREAD; p++) begin : g_rd
    assign rdData[p] = (rdAddr[p] == AW'(0)) ? '0 : bank[rdAddr[p]];
  end

endmodule

// File: rtl/mini_core_dpath.sv
`timescale 1ns/1ps
module mini_core_dpath
  import mini_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            loadEn,
  input  logic [IAW-1:0]  loadAddr,
  input  logic [XLEN-1:0] loadData,
  input  ctrlT            ctl,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  input  logic [4:0]      dbgRegSel,
  output logic [XLEN-1:0] dbgRegData,
  input  logic [DAW-1:0]  dbgMemAddr,
  output logic [XLEN-1:0] dbgMemData,
  output logic [XLEN-1:0] pcOut
);

  logic [XLEN-1:0] pc, nextPc, pcPlus4, brTarget, jTarget;
  logic [XLEN-1:0] instr, immExt, rsVal, rtVal, aluB, aluRes, loadVal, wbData;
  logic [4:0]      rsIdx, rtIdx, rdIdx, shamt, wrAddr;
  logic            takeBr, sameOps;
  logic [DAW-1:0]  memIdx;

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // Instruction array and fetch
  always_ff @(posedge clk) begin
    if (loadEn) imem[loadAddr] <= loadData;
  end

  assign instr  = imem[pc[IAW+1:2]];
  assign opcode = instr[31:26];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];
  assign immExt = {{16{instr[15]}}, instr[15:0]};

  // Register file
  logic [4:0]      rfAddr [3];
  logic [XLEN-1:0] rfData [3];

  assign rfAddr[0]  = rsIdx;
  assign rfAddr[1]  = rtIdx;
  assign rfAddr[2]  = dbgRegSel;
  assign rsVal      = rfData[0];
  assign rtVal      = rfData[1];
  assign dbgRegData = rfData[2];
  assign wrAddr     = ctl.dstIsRd ? rdIdx : rtIdx;

  mini_core_regs #(.NREG(32), .WIDTH(XLEN), .NREAD(3)) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .rdAddr (rfAddr),
    .rdData (rfData),
    .wrEn   (ctl.regWrite),
    .wrAddr (wrAddr),
    .wrData (wbData)
  );

  // ALU
  assign aluB = ctl.srcImm ? immExt : rtVal;

  always_comb begin
    unique case (ctl.aluOp)
      ALU_ADD: aluRes = rsVal + aluB;
      ALU_SUB: aluRes = rsVal - aluB;
      ALU_SLT: aluRes = {{(XLEN-1){1'b0}}, ($signed(rsVal) < $signed(aluB))};
      ALU_SRL: aluRes = rtVal >> shamt;
      default: aluRes = '0;
    endcase
  end

  // Data array
  assign memIdx     = aluRes[DAW+1:2];
  assign loadVal    = dmem[memIdx];
  assign dbgMemData = dmem[dbgMemAddr];
  assign wbData     = ctl.memToReg ? loadVal : aluRes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
    end else if (ctl.memWrite) begin
      dmem[memIdx] <= rtVal;
    end
  end

  // Next PC
  assign pcPlus4  = pc + 32'd4;
  assign brTarget = pcPlus4 + {immExt[29:0], 2'b00};
  assign jTarget  = {pcPlus4[31:28], instr[25:0], 2'b00};
  assign sameOps  = (rsVal == rtVal);
  assign takeBr   = (ctl.brEq && sameOps) || (ctl.brNe && !sameOps);

  always_comb begin
    if (ctl.jump)      nextPc = jTarget;
    else if (takeBr)   nextPc = brTarget;
    else               nextPc = pcPlus4;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= '0;
    else       pc <= nextPc;
  end

  assign pcOut = pc;

  // Assertions
  p_pc_aligned_r10: assert property (@(posedge clk) disable iff (!rstN)
    pc[1:0] == 2'b00);

  p_seq_advance_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.jump && !takeBr) |=> (pc == $past(pc) + 32'd4));

  p_branch_dest_r7: assert property (@(posedge clk) disable iff (!rstN)
    (takeBr && !ctl.jump) |=> (pc == $past(pc) + 32'd4 + ($past(immExt) << 2)));

  p_r0_source_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rsIdx == 5'd0) |-> (rsVal == '0));

  p_slt_boolean_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.aluOp == ALU_SLT && ctl.regWrite) |-> (aluRes[XLEN-1:1] == '0));

  p_store_no_wb_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWrite |-> !ctl.regWrite);

  p_one_flow_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.brEq, ctl.brNe, ctl.jump}));

endmodule

// File: rtl/mini_core.sv
`timescale 1ns/1ps
module mini_core
  import mini_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            loadEn,
  input  logic [IAW-1:0]  loadAddr,
  input  logic [31:0]     loadData,
  input  logic [4:0]      dbgRegSel,
  output logic [31:0]     dbgRegData,
  input  logic [DAW-1:0]  dbgMemAddr,
  output logic [31:0]     dbgMemData,
  output logic [31:0]     pcOut
);

  ctrlT       ctl;
  logic [5:0] opcode;
  logic [5:0] funct;

  mini_core_ctrl u_ctrl (
    .opcode (opcode),
    .funct  (funct),
    .ctl    (ctl)
  );

  mini_core_dpath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .loadEn     (loadEn),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .ctl        (ctl),
    .opcode     (opcode),
    .funct      (funct),
    .dbgRegSel  (dbgRegSel),
    .dbgRegData (dbgRegData),
    .dbgMemAddr (dbgMemAddr),
    .dbgMemData (dbgMemData),
    .pcOut      (pcOut)
  );

endmodule

// File: tb/mini_core_test.sv
`timescale 1ns/1ps
module mini_core_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [5:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [4:0]  dbgRegSel = '0;
  logic [5:0]  dbgMemAddr = '0;
  logic [31:0] dbgRegData, dbgMemData, pcOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [31:0] prog [64];

  always #2 clk = ~clk;  // 250 MHz

  mini_core uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .dbgRegSel(dbgRegSel), .dbgRegData(dbgRegData),
    .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData), .pcOut(pcOut)
  );

  function automatic logic [31:0] encR(input int rs, input int rt, input int rd,
                                       input int sh, input int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction

  function automatic logic [31:0] encI(input int op, input int rs, input int rt,
                                       input logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] encJ(input int op, input int tgt);
    return {op[5:0], tgt[25:0]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic readReg(input int idx, output logic [31:0] v);
    dbgRegSel = idx[4:0];
    #0.5;
    v = dbgRegData;
  endtask

  task automatic readMem(input int idx, output logic [31:0] v);
    dbgMemAddr = idx[5:0];
    #0.5;
    v = dbgMemData;
  endtask

  task automatic loadWord(input int addr, input logic [31:0] word);
    @(negedge clk);
    loadEn   = 1'b1;
    loadAddr = addr[5:0];
    loadData = word;
    @(negedge clk);
    loadEn   = 1'b0;
  endtask

  task automatic stepTo(inout int done, input int target);
    while (done < target) begin
      @(negedge clk);
      done++;
    end
  endtask

  // {requirement number, register, expected value} after the full run
  localparam int NEXP = 18;
  localparam logic [40:0] REG_EXP [NEXP] = '{
    {4'd2, 5'd0,  32'h0000_0000},  // R2 write to r0 dropped
    {4'd3, 5'd1,  32'h0000_0005},  // R3 addi
    {4'd3, 5'd2,  32'hFFFF_FFFD},  // R3 addi negative immediate
    {4'd3, 5'd3,  32'h0000_0002},  // R3 add wraps
    {4'd3, 5'd4,  32'hFFFF_FFF8},  // R3 sub
    {4'd4, 5'd5,  32'h0000_0001},  // R4 signed -3 < 5
    {4'd4, 5'd6,  32'h0000_0000},  // R4 signed 5 < -3 false
    {4'd5, 5'd7,  32'h0FFF_FFFF},  // R5 zero fill
    {4'd2, 5'd8,  32'h0000_0040},  // R2 r0 reads zero as source
    {4'd6, 5'd9,  32'hFFFF_FFF8},  // R6 load positive offset
    {4'd6, 5'd10, 32'h0000_0005},  // R6 load negative offset
    {4'd7, 5'd11, 32'h0000_0001},  // R7 not-taken beq falls through
    {4'd7, 5'd12, 32'h0000_0000},  // R7 skipped by taken branches
    {4'd8, 5'd13, 32'h0000_0000},  // R8 skipped by jump
    {4'd9, 5'd14, 32'h0000_0000},  // R9 unknown funct writes nothing
    {4'd3, 5'd15, 32'h0000_7FFF},  // R3 largest positive immediate
    {4'd7, 5'd16, 32'h0000_0005},  // R7 backward loop count
    {4'd4, 5'd17, 32'h0000_0000}   // R4 loop exit flag
  };

  initial begin
    #20000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [31:0] v;

    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    prog[0]  = encI(8, 0, 1, 16'd5);
    prog[1]  = encI(8, 0, 2, 16'hFFFD);
    prog[2]  = encR(1, 2, 3, 0, 32);
    prog[3]  = encR(2, 1, 4, 0, 34);
    prog[4]  = encR(2, 1, 5, 0, 42);
    prog[5]  = encR(1, 2, 6, 0, 42);
    prog[6]  = encR(0, 2, 7, 4, 2);
    prog[7]  = encI(8, 0, 0, 16'd7);
    prog[8]  = encI(8, 0, 8, 16'd64);
    prog[9]  = encI(43, 8, 4, 16'd8);
    prog[10] = encI(43, 8, 1, 16'hFFFC);
    prog[11] = encI(35, 8, 9, 16'd8);
    prog[12] = encI(35, 8, 10, 16'hFFFC);
    prog[13] = encI(4, 1, 2, 16'd2);
    prog[14] = encI(8, 0, 11, 16'd1);
    prog[15] = encI(5, 1, 2, 16'd1);
    prog[16] = encI(8, 0, 12, 16'd99);
    prog[17] = encI(4, 3, 3, 16'd1);
    prog[18] = encI(8, 0, 12, 16'd98);
    prog[19] = encJ(2, 22);
    prog[20] = encI(8, 0, 13, 16'd77);
    prog[21] = encI(8, 0, 13, 16'd66);
    prog[22] = 32'hFC00_0000;
    prog[23] = encR(1, 1, 14, 0, 63);
    prog[24] = encI(8, 0, 15, 16'h7FFF);
    prog[25] = encI(8, 16, 16, 16'd1);
    prog[26] = encR(16, 1, 17, 0, 42);
    prog[27] = encI(5, 17, 0, 16'hFFFD);
    prog[28] = encJ(2, 28);

    // R10 fill the instruction array while held in reset
    for (int i = 0; i < 64; i++) loadWord(i, prog[i]);

    // R1 reset state
    #0.5;
    check("R1", "pc in reset", pcOut, 32'h0);
    readReg(3, v);
    check("R1", "r3 in reset", v, 32'h0);

    @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
    #0.5;
    check("R1", "pc after release", pcOut, 32'h0);

    stepTo(cyc, 1);
    check("R7", "pc after first step", pcOut, 32'd4);
    stepTo(cyc, 14);
    check("R7", "pc after untaken beq", pcOut, 32'd56);
    stepTo(cyc, 16);
    check("R7", "pc after taken bne", pcOut, 32'd68);
    stepTo(cyc, 17);
    check("R7", "pc after taken beq", pcOut, 32'd76);
    stepTo(cyc, 18);
    check("R8", "pc after jump", pcOut, 32'd88);
    stepTo(cyc, 20);
    check("R9", "pc after unknown words", pcOut, 32'd96);
    stepTo(cyc, 60);
    check("R8", "pc parked on self jump", pcOut, 32'd112);

    for (int k = 0; k < NEXP; k++) begin
      readReg(int'(REG_EXP[k][36:32]), v);
      checks++;
      if (v !== REG_EXP[k][31:0]) begin
        errors++;
        $display("FAIL R%0d register %0d: actual=%h expected=%h",
                 REG_EXP[k][40:37], REG_EXP[k][36:32], v, REG_EXP[k][31:0]);
      end
    end

    readMem(18, v);
    check("R6", "store base+8 to word 18", v, 32'hFFFF_FFF8);
    readMem(15, v);
    check("R6", "store base-4 to word 15", v, 32'h0000_0005);
    readMem(0, v);
    check("R9", "word 0 untouched", v, 32'h0);

    // R1 reset in the middle of a run acts at once
    @(negedge clk);
    rstN = 1'b0;
    #0.5;
    check("R1", "pc on mid-run reset", pcOut, 32'h0);
    readReg(16, v);
    check("R1", "r16 cleared", v, 32'h0);
    readMem(18, v);
    check("R1", "data word 18 cleared", v, 32'h0);

    // R10 reload the start of the program
    loadWord(0, encI(8, 0, 1, 16'h1234));
    loadWord(1, encJ(2, 1));
    @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
    stepTo(cyc, 2);
    readReg(1, v);
    check("R10", "reloaded word executed", v, 32'h0000_1234);
    check("R8", "jump to word 1", pcOut, 32'd4);
    stepTo(cyc, 3);
    check("R8", "jump to self holds", pcOut, 32'd4);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule